// File: doc/BRIEF.md
# Dual-Mode Carry-Less Word Multiplier

This block multiplies binary polynomials held in 32-bit words with a chain of shift-and-add stages. The multiplicand moves left by one place at each stage. Each bit of the multiplier word selects whether that stage's shifted value is XORed into the result. All arithmetic is carry-less, so every addition is a bitwise XOR.

A single mode input selects between two uses. In field mode the bit shifted out of each stage folds a runtime-supplied reduction polynomial back into the multiplicand, so the result is already reduced. In extended mode the reduction polynomial is forced to zero at every stage. Each stage also feeds the next lower bit of a second multiplicand word into its vacated least significant bit. The block then returns one word-aligned word of the unreduced product of a two-word operand and one multiplier word, which is the word a multi-word partial-product loop needs. Software sequences those loops; this block computes one word per request.

A request is presented with `in_valid`. The result is registered and appears one clock later, marked by `out_valid`.

Top module: `gfm_word_mul`

## Requirements
- R1: After reset, `y` is 0 and `out_valid` is 0.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high.
- R3: `y` is loaded only on a clock edge where `in_valid` is high. On any other edge `y` keeps its value.
- R4: With `mode` = 0 (field mode), `y` equals `a_hi`·`b` reduced modulo x^32 + `poly`. Here `poly` holds the coefficients of x^31..x^0 in bits 31..0, and the x^32 term is implied. `a_lo` has no effect in this mode.
- R5: With `mode` = 1 (extended mode), `y` equals the XOR, over every r from 0 to 31 with `b[r]` = 1, of bits 63..32 of the 64-bit value {`a_hi`,`a_lo`} shifted left by r. The r = 0 term is `a_hi` alone.
- R6: In extended mode, `poly` has no effect on `y`.
- R7: In either mode, `b` = 0 gives `y` = 0, and `b` = 1 gives `y` = `a_hi`.
- R8: In field mode with `poly` = 0, `y` equals the low 32 bits of the carry-less product `a_hi`·`b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; operands are sampled when high |
| mode | input | 1 | 0 = field (reduced), 1 = extended two-word (unreduced) |
| a_hi | input | 32 | Multiplicand word (upper word in extended mode) |
| a_lo | input | 32 | Lower multiplicand word, used in extended mode only |
| b | input | 32 | Multiplier word |
| poly | input | 32 | Reduction polynomial without its x^32 term |
| y | output | 32 | Registered result word |
| out_valid | output | 1 | High for one cycle when `y` carries a new result |

## Verification
The assertions check on every cycle the one-cycle relation between `in_valid` and `out_valid`, that `y` holds while no request arrives, and the two trivial multipliers (zero and one) in both modes. The full arithmetic can only be shown by the bench's scenarios. These are reduced products against varied polynomials, aligned two-word products, the insensitivity to `a_lo` in field mode and to `poly` in extended mode, and the agreement of a zero polynomial with the plain carry-less product.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
    localparam int unsigned WORD_W = 32;

    typedef enum logic {
        MODE_FIELD = 1'b0,
        MODE_EXT   = 1'b1
    } gfm_mode_e;
endpackage

// File: rtl/gfm_stage.sv
// One shift stage: shift left by one place, fold the polynomial back in when
// the outgoing bit is set, and fill the vacated bit from the lower word.
module gfm_stage #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] poly_i,
    input  logic         ext_i,
    input  logic         lo_bit_i,
    output logic [W-1:0] next_o
);
    logic [W-1:0] poly_gated;
    logic         fill_bit;

    always_comb begin
        poly_gated = poly_i & {W{~ext_i}};
        fill_bit   = lo_bit_i & ext_i;
        next_o     = {prev_i[W-2:0], fill_bit} ^ (poly_gated & {W{prev_i[W-1]}});
    end
endmodule

// File: rtl/gfm_array.sv
// Combinational multiplier array: W shifted multiplicands, selectively XORed.
module gfm_array #(
    parameter int unsigned W = 32
) (
    input  logic         ext_i,
    input  logic [W-1:0] a_hi_i,
    input  logic [W-1:0] a_lo_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] poly_i,
    output logic [W-1:0] prod_o
);
    logic [W-1:0] shv [W];
    logic [W-1:0] acc [W+1];

    assign shv[0] = a_hi_i;
    assign acc[0] = '0;

    for (genvar r = 0; r < W; r++) begin : g_stage
        if (r > 0) begin : g_shift
            gfm_stage #(.W(W)) u_stage (
                .prev_i   (shv[r-1]),
                .poly_i   (poly_i),
                .ext_i    (ext_i),
                .lo_bit_i (a_lo_i[W-r]),
                .next_o   (shv[r])
            );
        end
        assign acc[r+1] = acc[r] ^ (shv[r] & {W{b_i[r]}});
    end

    assign prod_o = acc[W];
endmodule

// File: rtl/gfm_word_mul.sv
module gfm_word_mul #(
    parameter int unsigned W = gfm_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         mode,
    input  logic [W-1:0] a_hi,
    input  logic [W-1:0] a_lo,
    input  logic [W-1:0] b,
    input  logic [W-1:0] poly,
    output logic [W-1:0] y,
    output logic         out_valid
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         vld;
    } out_reg_t;

    out_reg_t     st_d, st_q;
    logic [W-1:0] prod;
    logic         ext_sel;

    assign ext_sel = (gfm_pkg::gfm_mode_e'(mode) == gfm_pkg::MODE_EXT);

    gfm_array #(.W(W)) u_array (
        .ext_i  (ext_sel),
        .a_hi_i (a_hi),
        .a_lo_i (a_lo),
        .b_i    (b),
        .poly_i (poly),
        .prod_o (prod)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = prod;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign y         = st_q.res;
    assign out_valid = st_q.vld;

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(y));
    p_zero_mult_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && b == '0) |=> (y == '0));
    p_unit_mult_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && b == W'(1)) |=> (y == $past(a_hi)));
endmodule

// File: tb/sim_gfm_word_mul.sv
`timescale 1ns/1ps
module sim_gfm_word_mul;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        mode = 1'b0;
    logic [31:0] a_hi = '0, a_lo = '0, b = '0, poly = '0;
    logic [31:0] y;
    logic        out_valid;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    gfm_word_mul u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .a_hi(a_hi), .a_lo(a_lo), .b(b), .poly(poly),
        .y(y), .out_valid(out_valid)
    );

    function automatic logic [31:0] ref_field(input logic [31:0] x, input logic [31:0] m, input logic [31:0] p);
        logic [63:0] prod = '0;
        for (int i = 0; i < 32; i++)
            if (m[i]) prod ^= (64'(x) << i);
        for (int k = 63; k >= 32; k--)
            if (prod[k]) begin
                prod[k] = 1'b0;
                prod ^= (64'(p) << (k - 32));
            end
        return prod[31:0];
    endfunction

    function automatic logic [31:0] ref_ext(input logic [31:0] hi, input logic [31:0] lo, input logic [31:0] m);
        logic [31:0] r = '0;
        logic [63:0] t;
        for (int i = 0; i < 32; i++) begin
            t = {hi, lo} << i;
            if (m[i]) r ^= t[63:32];
        end
        return r;
    endfunction

    function automatic logic [31:0] ref_clmul_lo(input logic [31:0] x, input logic [31:0] m);
        logic [31:0] r = '0;
        for (int i = 0; i < 32; i++)
            if (m[i]) r ^= (x << i);
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic m, input logic [31:0] hi, input logic [31:0] lo,
                          input logic [31:0] mb, input logic [31:0] p,
                          input string req, input logic [31:0] exp);
        @(negedge clk);
        mode = m; a_hi = hi; a_lo = lo; b = mb; poly = p; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " out_valid"}, {31'b0, out_valid}, 32'd1);
        check(req, y, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] h, l, mm, pp, held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 y", y, 32'd0);
        check("R1 out_valid", {31'b0, out_valid}, 32'd0);
        rst_n = 1'b1;

        // R7 directed: trivial multipliers in both modes
        run_op(1'b0, 32'hDEADBEEF, 32'h12345678, 32'd0, 32'h0000008D, "R7 field b=0", 32'd0);
        run_op(1'b1, 32'hDEADBEEF, 32'h12345678, 32'd0, 32'h0000008D, "R7 ext b=0", 32'd0);
        run_op(1'b0, 32'hCAFEF00D, 32'hFFFFFFFF, 32'd1, 32'h0000008D, "R7 field b=1", 32'hCAFEF00D);
        run_op(1'b1, 32'hCAFEF00D, 32'hFFFFFFFF, 32'd1, 32'h0000008D, "R7 ext b=1", 32'hCAFEF00D);

        // R4 directed: x^31 * x reduces to poly
        run_op(1'b0, 32'h80000000, 32'd0, 32'd2, 32'h0000008D, "R4 single fold", 32'h0000008D);
        run_op(1'b0, 32'hFFFFFFFF, 32'd0, 32'hFFFFFFFF, 32'hAF,
               "R4 all ones", ref_field(32'hFFFFFFFF, 32'hFFFFFFFF, 32'hAF));
        // R5 directed: top multiplier bit takes lo bits down to bit 1
        run_op(1'b1, 32'h00000001, 32'hFFFFFFFF, 32'h80000000, 32'd0, "R5 r=31", 32'hFFFFFFFF);
        run_op(1'b1, 32'h00000000, 32'h80000000, 32'h00000002, 32'hFFFFFFFF, "R5 r=1 lo msb", 32'h00000001);

        // R3: hold while in_valid is low and operands change
        held = y;
        @(negedge clk);
        mode = 1'b0; a_hi = 32'h13579BDF; b = 32'h2468ACE0; poly = 32'h1;
        repeat (3) @(negedge clk);
        check("R3 y held", y, held);
        check("R2 no valid", {31'b0, out_valid}, 32'd0);

        for (int n = 0; n < 150; n++) begin
            h = $urandom(); l = $urandom(); mm = $urandom(); pp = $urandom();
            run_op(1'b0, h, l, mm, pp, "R4 field random", ref_field(h, l == l ? mm : mm, pp));
            run_op(1'b0, h, ~l, mm, pp, "R4 a_lo ignored", ref_field(h, mm, pp));
            run_op(1'b1, h, l, mm, pp, "R5 ext random", ref_ext(h, l, mm));
            run_op(1'b1, h, l, mm, ~pp, "R6 poly ignored", ref_ext(h, l, mm));
            run_op(1'b0, h, l, mm, 32'd0, "R8 zero poly", ref_clmul_lo(h, mm));
        end

        // R2: back-to-back requests keep out_valid high each cycle
        @(negedge clk);
        mode = 1'b1; a_hi = 32'h1; a_lo = 32'h0; b = 32'h1; in_valid = 1'b1;
        @(negedge clk);
        check("R2 b2b first", {31'b0, out_valid}, 32'd1);
        a_hi = 32'h5;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 b2b second", {31'b0, out_valid}, 32'd1);
        check("R2 b2b data", y, 32'h5);
        @(negedge clk);
        check("R2 drop", {31'b0, out_valid}, 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule